// File: doc/BRIEF.md
# Power-Good Status Aggregator

This block folds the comparator results of a set of regulator channels, an input-supply monitor and a thermal warning into a single power-good indication. Each regulator channel, switching or linear, presents an undervoltage flag, an overvoltage flag and a current-limit flag. It also presents its regulator-enable bit, its monitor-enable bit and a select bit that decides whether current limit counts toward the result. Static configuration bits pick the voltage window (undervoltage only, or undervoltage and overvoltage) and the thermal mask. Two more bits let either of two active-low reset lines hold the output inactive. The remaining bits set the output polarity and the drive type.

The raw comparator flags pass through a two-flop synchronizer. They are then combined with the configuration into a non-latching "all good" term. A single output register captures that term on every clock. The output therefore follows the present conditions and returns active as soon as every offending condition clears. The pad stage, which is combinational after the register, provides a data bit and an output-enable bit. In open-drain mode the pad only ever pulls low, so other sources can share the line as a wired-AND.

Top module: `pg_aggregator`

## Requirements
- R1: While reset is asserted, and after it until the first evaluation, the internal good state is inactive. A change on a raw comparator flag reaches the output on the third rising edge after it is applied. A change on a configuration or reset-gate input reaches the output on the first rising edge after it is applied.
- R2: With the window bit at 0, only undervoltage flags of monitored sources count. With the window bit at 1, both undervoltage and overvoltage flags count.
- R3: A channel's current-limit flag counts only when that channel's select bit, monitor-enable bit and regulator-enable bit are all 1.
- R4: A channel with monitor-enable at 0 always contributes good, whatever its flags are.
- R5: A channel with monitor-enable at 1 and regulator-enable at 0 still contributes its voltage flags, as a monitor for an external rail.
- R6: The input-supply monitor flags count only when both its select bit and its enable bit are 1.
- R7: A thermal warning makes the output inactive unless the thermal mask bit is 1.
- R8: The good state is the AND of all included sources. It is not latched, so it returns active once every offending condition has cleared.
- R9: When gate-enable A is 1 and reset A is low, the output is held inactive. Gate-enable B and reset B behave the same way.
- R10: The pad level is the good state XOR the polarity bit. With polarity 0, good is a high level. With polarity 1, good is a low level.
- R11: In push-pull mode (od_mode=0), pg_oe is 1 and pg_o equals the pad level. In open-drain mode (od_mode=1), pg_o is 0 and pg_oe is 1 exactly when the pad level is low; otherwise the pad is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_uv | input | NUM_SW | Switching-channel undervoltage flags (raw) |
| sw_ov | input | NUM_SW | Switching-channel overvoltage flags (raw) |
| sw_ilim | input | NUM_SW | Switching-channel current-limit flags (raw) |
| sw_reg_en | input | NUM_SW | Switching-channel regulator enables |
| sw_mon_en | input | NUM_SW | Switching-channel monitor enables |
| sw_ilim_sel | input | NUM_SW | Switching-channel current-limit select |
| lin_uv | input | NUM_LIN | Linear-channel undervoltage flags (raw) |
| lin_ov | input | NUM_LIN | Linear-channel overvoltage flags (raw) |
| lin_ilim | input | NUM_LIN | Linear-channel current-limit flags (raw) |
| lin_reg_en | input | NUM_LIN | Linear-channel regulator enables |
| lin_mon_en | input | NUM_LIN | Linear-channel monitor enables |
| lin_ilim_sel | input | NUM_LIN | Linear-channel current-limit select |
| vin_uv | input | 1 | Input-supply undervoltage flag (raw) |
| vin_ov | input | 1 | Input-supply overvoltage flag (raw) |
| vin_mon_en | input | 1 | Input-supply monitor enable |
| vin_sel | input | 1 | Include input-supply monitor |
| therm_warn | input | 1 | Thermal warning flag (raw) |
| therm_mask | input | 1 | Exclude thermal warning |
| window_ov | input | 1 | 1: check overvoltage as well as undervoltage |
| rst_a_n | input | 1 | Gating reset A, active low |
| rst_b_n | input | 1 | Gating reset B, active low |
| gate_a_en | input | 1 | Let reset A hold the output inactive |
| gate_b_en | input | 1 | Let reset B hold the output inactive |
| pol_inv | input | 1 | 1: good is a low level |
| od_mode | input | 1 | 1: open-drain drive |
| pg_o | output | 1 | Pad output data |
| pg_oe | output | 1 | Pad output enable |

## Verification
On every cycle, the assertions check several properties. The output drive obeys its mode. A thermal warning or an asserted gating reset forces the good state low one edge later. A fully clean synchronized input set, or a set where every source is excluded, produces good one edge later. Reset leaves the state inactive. The bench scenarios cover the rest: the per-channel interplay of the select, monitor-enable and regulator-enable bits; the window bit; the input-supply inclusion; the exact three-edge flag latency; the non-latching recovery; and the wired-AND behaviour with another open-drain source.

// File: rtl/pg_aggregator.sv
module pg_aggregator #(
  parameter int NUM_SW  = 4,
  parameter int NUM_LIN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SW-1:0]  sw_uv,
  input  logic [NUM_SW-1:0]  sw_ov,
  input  logic [NUM_SW-1:0]  sw_ilim,
  input  logic [NUM_SW-1:0]  sw_reg_en,
  input  logic [NUM_SW-1:0]  sw_mon_en,
  input  logic [NUM_SW-1:0]  sw_ilim_sel,
  input  logic [NUM_LIN-1:0] lin_uv,
  input  logic [NUM_LIN-1:0] lin_ov,
  input  logic [NUM_LIN-1:0] lin_ilim,
  input  logic [NUM_LIN-1:0] lin_reg_en,
  input  logic [NUM_LIN-1:0] lin_mon_en,
  input  logic [NUM_LIN-1:0] lin_ilim_sel,
  input  logic               vin_uv,
  input  logic               vin_ov,
  input  logic               vin_mon_en,
  input  logic               vin_sel,
  input  logic               therm_warn,
  input  logic               therm_mask,
  input  logic               window_ov,
  input  logic               rst_a_n,
  input  logic               rst_b_n,
  input  logic               gate_a_en,
  input  logic               gate_b_en,
  input  logic               pol_inv,
  input  logic               od_mode,
  output logic               pg_o,
  output logic               pg_oe
);
  localparam int NCH   = NUM_SW + NUM_LIN;
  localparam int NFLAG = 3 * NCH + 3;

  logic [NFLAG-1:0] raw, sync1, sync2;
  logic [NCH-1:0]   ch_uv, ch_ov, ch_ilim, ch_mon, ch_reg, ch_sel, ch_bad;
  logic             vin_uv_s, vin_ov_s, therm_s;
  logic             vin_bad, therm_bad, gate_bad, good_d, good_q, level;

  assign raw = {therm_warn, vin_ov, vin_uv, lin_ilim, sw_ilim,
                lin_ov, sw_ov, lin_uv, sw_uv};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
    end
  end

  assign ch_uv    = sync2[NCH-1:0];
  assign ch_ov    = sync2[2*NCH-1:NCH];
  assign ch_ilim  = sync2[3*NCH-1:2*NCH];
  assign vin_uv_s = sync2[3*NCH];
  assign vin_ov_s = sync2[3*NCH+1];
  assign therm_s  = sync2[3*NCH+2];

  assign ch_mon = {lin_mon_en, sw_mon_en};
  assign ch_reg = {lin_reg_en, sw_reg_en};
  assign ch_sel = {lin_ilim_sel, sw_ilim_sel};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_bad[i] = ch_mon[i] &
                       (ch_uv[i] | (window_ov & ch_ov[i]) |
                        (ch_sel[i] & ch_reg[i] & ch_ilim[i]));
  end

  assign vin_bad   = vin_sel & vin_mon_en & (vin_uv_s | (window_ov & vin_ov_s));
  assign therm_bad = therm_s & ~therm_mask;
  assign gate_bad  = (gate_a_en & ~rst_a_n) | (gate_b_en & ~rst_b_n);
  assign good_d    = ~(|ch_bad | vin_bad | therm_bad | gate_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_q <= 1'b0;
    else        good_q <= good_d;
  end

  assign level = good_q ^ pol_inv;
  assign pg_o  = od_mode ? 1'b0 : level;
  assign pg_oe = od_mode ? ~level : 1'b1;
endmodule

module pg_aggregator_chk #(
  parameter int NFLAG = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] sync2,
  input logic             good_q,
  input logic             therm_mask,
  input logic             rst_a_n,
  input logic             rst_b_n,
  input logic             gate_a_en,
  input logic             gate_b_en,
  input logic             od_mode,
  input logic             pg_o,
  input logic             pg_oe,
  input logic             vin_sel,
  input logic [8:0]       mon_all
);
  p_reset_inactive_r1: assert property (@(posedge clk) !rst_n |=> !good_q);

  p_therm_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2[NFLAG-1] && !therm_mask) |=> !good_q);

  p_gate_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a_en && !rst_a_n) |=> !good_q);

  p_gate_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_b_en && !rst_b_n) |=> !good_q);

  p_clean_recovers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2 == '0 && !(gate_a_en && !rst_a_n) && !(gate_b_en && !rst_b_n)) |=> good_q);

  p_all_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_all == '0 && !vin_sel && therm_mask && !gate_a_en && !gate_b_en) |=> good_q);

  p_od_never_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    od_mode |-> !(pg_oe && pg_o));

  p_pp_drives_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !od_mode |-> pg_oe);
endmodule

bind pg_aggregator pg_aggregator_chk #(.NFLAG(NFLAG)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync2(sync2), .good_q(good_q),
  .therm_mask(therm_mask), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
  .gate_a_en(gate_a_en), .gate_b_en(gate_b_en), .od_mode(od_mode),
  .pg_o(pg_o), .pg_oe(pg_oe), .vin_sel(vin_sel), .mon_all(9'(ch_mon))
);

// File: tb/pg_aggregator_tb.sv
`timescale 1ns/1ps
module pg_aggregator_tb_top;
  localparam int NSW = 4;
  localparam int NLN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSW-1:0] sw_uv, sw_ov, sw_ilim, sw_reg_en, sw_mon_en, sw_ilim_sel;
  logic [NLN-1:0] lin_uv, lin_ov, lin_ilim, lin_reg_en, lin_mon_en, lin_ilim_sel;
  logic vin_uv, vin_ov, vin_mon_en, vin_sel, therm_warn, therm_mask, window_ov;
  logic rst_a_n, rst_b_n, gate_a_en, gate_b_en, pol_inv, od_mode;
  logic pg_o, pg_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pg_aggregator #(.NUM_SW(NSW), .NUM_LIN(NLN)) dut_i (.*);

  function automatic bit exp_good();
    bit bad = 0;
    for (int i = 0; i < NSW; i++)
      if (sw_mon_en[i] && (sw_uv[i] || (window_ov && sw_ov[i]) ||
          (sw_ilim_sel[i] && sw_reg_en[i] && sw_ilim[i]))) bad = 1;
    for (int i = 0; i < NLN; i++)
      if (lin_mon_en[i] && (lin_uv[i] || (window_ov && lin_ov[i]) ||
          (lin_ilim_sel[i] && lin_reg_en[i] && lin_ilim[i]))) bad = 1;
    if (vin_sel && vin_mon_en && (vin_uv || (window_ov && vin_ov))) bad = 1;
    if (therm_warn && !therm_mask) bad = 1;
    if ((gate_a_en && !rst_a_n) || (gate_b_en && !rst_b_n)) bad = 1;
    return !bad;
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // pad check: {pg_oe, pg_o} against expected good
  task automatic chk_pad(input string tag, input bit g);
    bit lvl = g ^ pol_inv;
    chk(tag, {pg_oe, pg_o}, od_mode ? {~lvl, 1'b0} : {1'b1, lvl});
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clean();
    {sw_uv, sw_ov, sw_ilim, lin_uv, lin_ov, lin_ilim} = '0;
    sw_reg_en = '1; sw_mon_en = '1; sw_ilim_sel = '1;
    lin_reg_en = '1; lin_mon_en = '1; lin_ilim_sel = '1;
    vin_uv = 0; vin_ov = 0; vin_mon_en = 1; vin_sel = 1;
    therm_warn = 0; therm_mask = 0; window_ov = 1;
    rst_a_n = 1; rst_b_n = 1; gate_a_en = 1; gate_b_en = 1;
    pol_inv = 0; od_mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_9bdf));
    clean();
    step(2);
    chk("R1 reset inactive", {pg_oe, pg_o}, 2'b10);
    rst_n = 1;
    step(4);
    chk_pad("R8 all clean good", 1);

    // R1 latency of a raw flag: three edges
    sw_uv[1] = 1;
    step(1); chk_pad("R1 flag after 1 edge", 1);
    step(1); chk_pad("R1 flag after 2 edges", 1);
    step(1); chk_pad("R1 flag after 3 edges", 0);
    sw_uv[1] = 0;
    step(3); chk_pad("R8 non-latching recovery", 1);

    // R2 window
    lin_ov[2] = 1; window_ov = 0;
    step(4); chk_pad("R2 ov ignored in uv-only window", 1);
    window_ov = 1;
    step(1); chk_pad("R2 ov counted in full window", 0);
    lin_ov[2] = 0; step(4);

    // R3 current limit qualifiers
    sw_ilim[0] = 1; sw_ilim_sel[0] = 0;
    step(4); chk_pad("R3 ilim ignored when select 0", 1);
    sw_ilim_sel[0] = 1; sw_reg_en[0] = 0;
    step(1); chk_pad("R3 ilim ignored when regulator off", 1);
    sw_reg_en[0] = 1;
    step(1); chk_pad("R3 ilim counted", 0);
    sw_mon_en[0] = 0;
    step(1); chk_pad("R3 ilim ignored when monitor off", 1);
    sw_ilim[0] = 0; sw_mon_en[0] = 1;

    // R4 / R5
    lin_uv[4] = 1; lin_ov[4] = 1; lin_mon_en[4] = 0;
    step(4); chk_pad("R4 unmonitored channel good", 1);
    lin_mon_en[4] = 1; lin_reg_en[4] = 0;
    step(1); chk_pad("R5 external-rail monitor counts", 0);
    lin_uv[4] = 0; lin_ov[4] = 0; lin_reg_en[4] = 1; step(4);

    // R6
    vin_uv = 1; vin_sel = 0;
    step(4); chk_pad("R6 vin excluded by select", 1);
    vin_sel = 1; vin_mon_en = 0;
    step(1); chk_pad("R6 vin excluded by enable", 1);
    vin_mon_en = 1;
    step(1); chk_pad("R6 vin included", 0);
    vin_uv = 0; step(4);

    // R7
    therm_warn = 1; therm_mask = 1;
    step(4); chk_pad("R7 thermal masked", 1);
    therm_mask = 0;
    step(1); chk_pad("R7 thermal unmasked", 0);
    therm_warn = 0; step(4);

    // R9 gating, one edge latency
    rst_a_n = 0;
    step(1); chk_pad("R9 gate A holds", 0);
    gate_a_en = 0;
    step(1); chk_pad("R9 gate A disabled", 1);
    rst_b_n = 0;
    step(1); chk_pad("R9 gate B holds", 0);
    rst_a_n = 1; rst_b_n = 1; gate_a_en = 1;

    // R10 / R11 drive modes incl. wired-AND with another open-drain source
    pol_inv = 1; step(1); chk_pad("R10 inverted polarity good", 1);
    od_mode = 1; pol_inv = 0; step(1);
    chk("R11 od released when good high", {pg_oe, pg_o}, 2'b00);
    chk("R11 wired-AND other source low", (pg_oe ? pg_o : 1'b1) & 1'b0, 1'b0);
    sw_uv[3] = 1; step(4);
    chk("R11 od pulls low when bad", {pg_oe, pg_o}, 2'b10);
    chk("R11 wired-AND with other released", (pg_oe ? pg_o : 1'b1) & 1'b1, 1'b0);
    sw_uv[3] = 0; step(4);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      sw_uv = NSW'($urandom & $urandom & $urandom);
      sw_ov = NSW'($urandom & $urandom & $urandom);
      sw_ilim = NSW'($urandom & $urandom);
      lin_uv = NLN'($urandom & $urandom & $urandom);
      lin_ov = NLN'($urandom & $urandom & $urandom);
      lin_ilim = NLN'($urandom & $urandom);
      sw_reg_en = NSW'($urandom); sw_mon_en = NSW'($urandom | $urandom);
      sw_ilim_sel = NSW'($urandom);
      lin_reg_en = NLN'($urandom); lin_mon_en = NLN'($urandom | $urandom);
      lin_ilim_sel = NLN'($urandom);
      {vin_uv, vin_ov, vin_mon_en, vin_sel} = 4'($urandom);
      therm_warn = ($urandom % 4) == 0; therm_mask = 1'($urandom);
      window_ov = 1'($urandom);
      {rst_a_n, rst_b_n} = 2'($urandom | $urandom);
      {gate_a_en, gate_b_en, pol_inv, od_mode} = 4'($urandom);
      step(4);
      chk_pad("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random", exp_good());
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule